// File: doc/BRIEF.md
# Write-Through Data Cache with Instruction-Cache Update

This block is a small direct-mapped data cache for a processor whose words are 12 bits wide and whose word address is 15 bits: a 3-bit field selector sits above a 12-bit offset. Two load requesters share it, one that fetches indirect pointers and one that fetches execute operands. Each requester presents an address every cycle it needs a word. It receives either a hit with the word, or a miss, in which case it stalls and presents the same address again in the following cycles. For every missing lookup the cache raises a line-fill command on that requester's own memory channel, but only when that channel reports it can take a command.

Memory answers with whole lines on two response inputs, one per requester. A response is written into the array and is also forwarded to the lookups of the same cycle, so a stalled requester hits in the cycle its line returns. Stores are write-through. Each store becomes a single-word masked write to memory, and the same address and data are offered to a companion instruction cache, so code that modifies itself stays coherent. A store patches a resident line in this cache and never allocates one.

Top module: `dcwt_top`

## Requirements
- R1: Reset clears every valid bit. After reset no lookup hits until a fill response has installed the addressed line.
- R2: The indirect port hits when its request is high, the line selected by address bits [5:3] is valid, and that line's tag equals address bits [14:6]. On a hit the data output is the word selected by address bits [2:0]. On a miss or with no request, the hit output is low and the data output is zero.
- R3: The execute port follows the same hit and data rule as R2, independently and in the same cycle as the indirect port.
- R4: A port whose request misses while its fill-ready input is high raises its fill-valid output in that same cycle. The fill line address is the word address shifted right by 3, which is bits [14:3].
- R5: Fill-valid is low whenever fill-ready is low, the request hits, or there is no request. A requester that keeps missing gets a fresh fill command in every cycle its channel is ready.
- R6: A fill response writes its line into index line[2:0], sets the tag to line[11:3] and sets the valid bit. The line is visible to lookups in the cycle the response is presented.
- R7: When both responses arrive in one cycle, the indirect response is installed first and the execute response second. If they target the same index, the execute line is the one that stays.
- R8: A store raises the write-valid output in the same cycle. The write line is the store address bits [14:3]. The write mask has only bit k set, where k is address bits [2:0]. Word slot k of the write data, which is bits [12k+11:12k], carries the store data, and every other slot is zero.
- R9: In the same cycle as a store, the instruction-cache update outputs carry the valid flag, the full 15-bit address and the data of that store.
- R10: A store whose line is resident after that cycle's fills overwrites the addressed word from the next cycle on. This includes a line that a response installs in the same cycle.
- R11: A store to a line that is not resident changes no tag, valid bit or data word. There is no write-allocate.
- R12: Lookups made in the cycle of a store see the word as it was before that store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ind_req | input | 1 | Indirect-port lookup request |
| ind_addr | input | 15 | Indirect-port word address |
| ind_hit | output | 1 | Indirect-port hit |
| ind_data | output | 12 | Indirect-port word, zero on miss |
| ind_fill_rdy | input | 1 | Indirect fill channel can accept a command |
| ind_fill_vld | output | 1 | Indirect fill command |
| ind_fill_line | output | 12 | Indirect fill line address |
| ind_rsp_vld | input | 1 | Indirect fill response valid |
| ind_rsp_line | input | 12 | Indirect fill response line address |
| ind_rsp_data | input | 96 | Indirect fill response line, word k at bits [12k+11:12k] |
| exe_req | input | 1 | Execute-port lookup request |
| exe_addr | input | 15 | Execute-port word address |
| exe_hit | output | 1 | Execute-port hit |
| exe_data | output | 12 | Execute-port word, zero on miss |
| exe_fill_rdy | input | 1 | Execute fill channel can accept a command |
| exe_fill_vld | output | 1 | Execute fill command |
| exe_fill_line | output | 12 | Execute fill line address |
| exe_rsp_vld | input | 1 | Execute fill response valid |
| exe_rsp_line | input | 12 | Execute fill response line address |
| exe_rsp_data | input | 96 | Execute fill response line |
| st_vld | input | 1 | Store request |
| st_addr | input | 15 | Store word address |
| st_data | input | 12 | Store data |
| wr_vld | output | 1 | Memory write command |
| wr_line | output | 12 | Memory write line address |
| wr_mask | output | 8 | One-hot word mask of the write |
| wr_data | output | 96 | Write line with the store word in its slot |
| ic_upd_vld | output | 1 | Instruction-cache update offer |
| ic_upd_addr | output | 15 | Instruction-cache update address |
| ic_upd_data | output | 12 | Instruction-cache update data |

## Verification
Three things can land in one cycle: a fill response installing a line, a lookup reading that line, and a store to it. The ordering rule is fill first, then the lookups, then the store patch. Directed cycles build each collision on purpose. One presents a response together with a lookup of the same line, which must hit at once. One presents a store together with a lookup of the same word, which must read the old value. One presents a store together with a fill of that line, after which the stored word must survive. One presents two responses to the same index, after which only the execute line may hit. A long random phase then draws addresses from a few tags, so responses, stores and lookups collide often, and every output is compared each cycle against a behavioural model that applies the same fill, lookup and store order.

// File: rtl/dcwt_pkg.sv
`timescale 1ns/1ps
// Shared constants for the write-through data cache.
package dcwt_pkg;
   localparam int unsigned WORD_BITS   = 12;  // machine word width
   localparam int unsigned FIELD_BITS  = 3;   // field selector above the offset
   localparam int unsigned OFFSET_BITS = 12;  // offset within one field
   // Fill sources, listed in install order: a higher number is applied later
   localparam int unsigned NUM_SRC = 2;
   localparam int unsigned SRC_IND = 0;
   localparam int unsigned SRC_EXE = 1;
endpackage

// File: rtl/dcwt_fill_merge.sv
`timescale 1ns/1ps
// Applies the fill responses of one cycle to the array, in source order.
module dcwt_fill_merge #(
   parameter  int unsigned WORD_W     = 12,
   parameter  int unsigned ADDR_W     = 15,
   parameter  int unsigned LINE_WORDS = 8,
   parameter  int unsigned LINES      = 8,
   parameter  int unsigned NSRC       = 2,
   localparam int unsigned OFS_W      = $clog2(LINE_WORDS),
   localparam int unsigned IDX_W      = $clog2(LINES),
   localparam int unsigned TAG_W      = ADDR_W - OFS_W - IDX_W,
   localparam int unsigned LADDR_W    = ADDR_W - OFS_W,
   localparam int unsigned LINE_W     = LINE_WORDS * WORD_W
) (
   input  logic [LINES-1:0]                cur_valid,
   input  logic [LINES-1:0][TAG_W-1:0]     cur_tag,
   input  logic [LINES-1:0][LINE_W-1:0]    cur_data,
   input  logic [NSRC-1:0]                 rsp_vld,
   input  logic [NSRC-1:0][LADDR_W-1:0]    rsp_line,
   input  logic [NSRC-1:0][LINE_W-1:0]     rsp_data,
   output logic [LINES-1:0]                eff_valid,
   output logic [LINES-1:0][TAG_W-1:0]     eff_tag,
   output logic [LINES-1:0][LINE_W-1:0]    eff_data
);
   always_comb begin
      eff_valid = cur_valid;
      eff_tag   = cur_tag;
      eff_data  = cur_data;
      // later sources overwrite earlier ones on an index collision
      for (int s = 0; s < int'(NSRC); s++) begin
         if (rsp_vld[s]) begin
            eff_valid[rsp_line[s][IDX_W-1:0]] = 1'b1;
            eff_tag[rsp_line[s][IDX_W-1:0]]   = rsp_line[s][LADDR_W-1 -: TAG_W];
            eff_data[rsp_line[s][IDX_W-1:0]]  = rsp_data[s];
         end
      end
   end
endmodule

// File: rtl/dcwt_lookup.sv
`timescale 1ns/1ps
// One load port: tag compare, word select and fill command on a miss.
module dcwt_lookup #(
   parameter  int unsigned WORD_W     = 12,
   parameter  int unsigned ADDR_W     = 15,
   parameter  int unsigned LINE_WORDS = 8,
   parameter  int unsigned LINES      = 8,
   localparam int unsigned OFS_W      = $clog2(LINE_WORDS),
   localparam int unsigned IDX_W      = $clog2(LINES),
   localparam int unsigned TAG_W      = ADDR_W - OFS_W - IDX_W,
   localparam int unsigned LADDR_W    = ADDR_W - OFS_W,
   localparam int unsigned LINE_W     = LINE_WORDS * WORD_W
) (
   input  logic [LINES-1:0]             eff_valid,
   input  logic [LINES-1:0][TAG_W-1:0]  eff_tag,
   input  logic [LINES-1:0][LINE_W-1:0] eff_data,
   input  logic                         req,
   input  logic [ADDR_W-1:0]            addr,
   input  logic                         fill_rdy,
   output logic                         hit,
   output logic [WORD_W-1:0]            data,
   output logic                         fill_vld,
   output logic [LADDR_W-1:0]           fill_line
);
   logic [OFS_W-1:0] ofs;
   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;

   assign ofs = addr[OFS_W-1:0];
   assign idx = addr[OFS_W +: IDX_W];
   assign tag = addr[ADDR_W-1 -: TAG_W];

   assign hit       = req && eff_valid[idx] && (eff_tag[idx] == tag);
   assign data      = hit ? eff_data[idx][ofs*WORD_W +: WORD_W] : '0;
   // a miss only becomes a command when the channel can take it
   assign fill_vld  = req && !hit && fill_rdy;
   assign fill_line = addr[ADDR_W-1:OFS_W];
endmodule

// File: rtl/dcwt_store.sv
`timescale 1ns/1ps
// Write-through path: masked memory write, instruction-cache offer, local patch.
module dcwt_store #(
   parameter  int unsigned WORD_W     = 12,
   parameter  int unsigned ADDR_W     = 15,
   parameter  int unsigned LINE_WORDS = 8,
   parameter  int unsigned LINES      = 8,
   localparam int unsigned OFS_W      = $clog2(LINE_WORDS),
   localparam int unsigned IDX_W      = $clog2(LINES),
   localparam int unsigned TAG_W      = ADDR_W - OFS_W - IDX_W,
   localparam int unsigned LADDR_W    = ADDR_W - OFS_W,
   localparam int unsigned LINE_W     = LINE_WORDS * WORD_W
) (
   input  logic [LINES-1:0]             eff_valid,
   input  logic [LINES-1:0][TAG_W-1:0]  eff_tag,
   input  logic [LINES-1:0][LINE_W-1:0] eff_data,
   input  logic                         st_vld,
   input  logic [ADDR_W-1:0]            st_addr,
   input  logic [WORD_W-1:0]            st_data,
   output logic [LINES-1:0][LINE_W-1:0] nxt_data,
   output logic                         wr_vld,
   output logic [LADDR_W-1:0]           wr_line,
   output logic [LINE_WORDS-1:0]        wr_mask,
   output logic [LINE_W-1:0]            wr_data,
   output logic                         ic_upd_vld,
   output logic [ADDR_W-1:0]            ic_upd_addr,
   output logic [WORD_W-1:0]            ic_upd_data
);
   logic [OFS_W-1:0] s_ofs;
   logic [IDX_W-1:0] s_idx;
   logic [TAG_W-1:0] s_tag;
   logic             s_resident;

   assign s_ofs      = st_addr[OFS_W-1:0];
   assign s_idx      = st_addr[OFS_W +: IDX_W];
   assign s_tag      = st_addr[ADDR_W-1 -: TAG_W];
   assign s_resident = st_vld && eff_valid[s_idx] && (eff_tag[s_idx] == s_tag);

   assign wr_vld  = st_vld;
   assign wr_line = st_addr[ADDR_W-1:OFS_W];

   // one mask bit and one data slot per word of the line
   for (genvar w = 0; w < int'(LINE_WORDS); w++) begin : g_slot
      assign wr_mask[w] = st_vld && (s_ofs == OFS_W'(w));
      assign wr_data[w*WORD_W +: WORD_W] = wr_mask[w] ? st_data : '0;
   end

   assign ic_upd_vld  = st_vld;
   assign ic_upd_addr = st_addr;
   assign ic_upd_data = st_data;

   // patch only a resident line; tags and valid bits are never touched here
   always_comb begin
      nxt_data = eff_data;
      if (s_resident) begin
         nxt_data[s_idx][s_ofs*WORD_W +: WORD_W] = st_data;
      end
   end
endmodule

// File: rtl/dcwt_top.sv
`timescale 1ns/1ps
// Direct-mapped write-through data cache with two load ports.
module dcwt_top
   import dcwt_pkg::*;
#(
   parameter  int unsigned WORD_W     = WORD_BITS,
   parameter  int unsigned ADDR_W     = FIELD_BITS + OFFSET_BITS,
   parameter  int unsigned LINE_WORDS = 8,
   parameter  int unsigned LINES      = 8,
   localparam int unsigned OFS_W      = $clog2(LINE_WORDS),
   localparam int unsigned IDX_W      = $clog2(LINES),
   localparam int unsigned TAG_W      = ADDR_W - OFS_W - IDX_W,
   localparam int unsigned LADDR_W    = ADDR_W - OFS_W,
   localparam int unsigned LINE_W     = LINE_WORDS * WORD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ind_req,
   input  logic [ADDR_W-1:0]  ind_addr,
   output logic               ind_hit,
   output logic [WORD_W-1:0]  ind_data,
   input  logic               ind_fill_rdy,
   output logic               ind_fill_vld,
   output logic [LADDR_W-1:0] ind_fill_line,
   input  logic               ind_rsp_vld,
   input  logic [LADDR_W-1:0] ind_rsp_line,
   input  logic [LINE_W-1:0]  ind_rsp_data,
   input  logic               exe_req,
   input  logic [ADDR_W-1:0]  exe_addr,
   output logic               exe_hit,
   output logic [WORD_W-1:0]  exe_data,
   input  logic               exe_fill_rdy,
   output logic               exe_fill_vld,
   output logic [LADDR_W-1:0] exe_fill_line,
   input  logic               exe_rsp_vld,
   input  logic [LADDR_W-1:0] exe_rsp_line,
   input  logic [LINE_W-1:0]  exe_rsp_data,
   input  logic               st_vld,
   input  logic [ADDR_W-1:0]  st_addr,
   input  logic [WORD_W-1:0]  st_data,
   output logic               wr_vld,
   output logic [LADDR_W-1:0] wr_line,
   output logic [LINE_WORDS-1:0] wr_mask,
   output logic [LINE_W-1:0]  wr_data,
   output logic               ic_upd_vld,
   output logic [ADDR_W-1:0]  ic_upd_addr,
   output logic [WORD_W-1:0]  ic_upd_data
);
   // elaboration-time parameter checks
   if ((1 << OFS_W) != LINE_WORDS) begin : g_chk_words
      $error("LINE_WORDS must be a power of two");
   end
   if ((1 << IDX_W) != LINES) begin : g_chk_lines
      $error("LINES must be a power of two");
   end
   if (ADDR_W <= OFS_W + IDX_W) begin : g_chk_tag
      $error("ADDR_W leaves no tag bits");
   end

   // array state
   logic [LINES-1:0]              q_valid;
   logic [LINES-1:0][TAG_W-1:0]   q_tag;
   logic [LINES-1:0][LINE_W-1:0]  q_data;
   // after this cycle's fills
   logic [LINES-1:0]              f_valid;
   logic [LINES-1:0][TAG_W-1:0]   f_tag;
   logic [LINES-1:0][LINE_W-1:0]  f_data;
   // after this cycle's store
   logic [LINES-1:0][LINE_W-1:0]  s_data;

   logic [NUM_SRC-1:0]               rsp_vld;
   logic [NUM_SRC-1:0][LADDR_W-1:0]  rsp_line;
   logic [NUM_SRC-1:0][LINE_W-1:0]   rsp_data;

   assign rsp_vld[SRC_IND]  = ind_rsp_vld;
   assign rsp_line[SRC_IND] = ind_rsp_line;
   assign rsp_data[SRC_IND] = ind_rsp_data;
   assign rsp_vld[SRC_EXE]  = exe_rsp_vld;
   assign rsp_line[SRC_EXE] = exe_rsp_line;
   assign rsp_data[SRC_EXE] = exe_rsp_data;

   dcwt_fill_merge #(
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS),
      .LINES(LINES), .NSRC(NUM_SRC)
   ) u_fill (
      .cur_valid(q_valid), .cur_tag(q_tag), .cur_data(q_data),
      .rsp_vld(rsp_vld), .rsp_line(rsp_line), .rsp_data(rsp_data),
      .eff_valid(f_valid), .eff_tag(f_tag), .eff_data(f_data)
   );

   // per-port lookup bundles
   logic [NUM_SRC-1:0]               lk_req, lk_rdy, lk_hit, lk_fvld;
   logic [NUM_SRC-1:0][ADDR_W-1:0]   lk_addr;
   logic [NUM_SRC-1:0][WORD_W-1:0]   lk_data;
   logic [NUM_SRC-1:0][LADDR_W-1:0]  lk_fline;

   assign lk_req[SRC_IND]  = ind_req;
   assign lk_addr[SRC_IND] = ind_addr;
   assign lk_rdy[SRC_IND]  = ind_fill_rdy;
   assign lk_req[SRC_EXE]  = exe_req;
   assign lk_addr[SRC_EXE] = exe_addr;
   assign lk_rdy[SRC_EXE]  = exe_fill_rdy;

   for (genvar p = 0; p < int'(NUM_SRC); p++) begin : g_port
      dcwt_lookup #(
         .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
      ) u_lk (
         .eff_valid(f_valid), .eff_tag(f_tag), .eff_data(f_data),
         .req(lk_req[p]), .addr(lk_addr[p]), .fill_rdy(lk_rdy[p]),
         .hit(lk_hit[p]), .data(lk_data[p]),
         .fill_vld(lk_fvld[p]), .fill_line(lk_fline[p])
      );
   end

   assign ind_hit       = lk_hit[SRC_IND];
   assign ind_data      = lk_data[SRC_IND];
   assign ind_fill_vld  = lk_fvld[SRC_IND];
   assign ind_fill_line = lk_fline[SRC_IND];
   assign exe_hit       = lk_hit[SRC_EXE];
   assign exe_data      = lk_data[SRC_EXE];
   assign exe_fill_vld  = lk_fvld[SRC_EXE];
   assign exe_fill_line = lk_fline[SRC_EXE];

   dcwt_store #(
      .WORD_W(WORD_W), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .LINES(LINES)
   ) u_store (
      .eff_valid(f_valid), .eff_tag(f_tag), .eff_data(f_data),
      .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
      .nxt_data(s_data),
      .wr_vld(wr_vld), .wr_line(wr_line), .wr_mask(wr_mask), .wr_data(wr_data),
      .ic_upd_vld(ic_upd_vld), .ic_upd_addr(ic_upd_addr), .ic_upd_data(ic_upd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_valid <= '0;
      else        q_valid <= f_valid;
   end

   // tags and words need no reset: they are qualified by the valid bits
   always_ff @(posedge clk) begin
      q_tag  <= f_tag;
      q_data <= s_data;
   end
endmodule

// File: rtl/dcwt_chk.sv
`timescale 1ns/1ps
// Port-level properties of the data cache, bound to the top module.
module dcwt_chk #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned OFS_W      = 3,
   parameter int unsigned LINE_WORDS = 8,
   parameter int unsigned WORD_W     = 12
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      ind_req,
   input logic [ADDR_W-1:0]         ind_addr,
   input logic                      ind_hit,
   input logic                      ind_fill_rdy,
   input logic                      ind_fill_vld,
   input logic [ADDR_W-OFS_W-1:0]   ind_fill_line,
   input logic                      ind_rsp_vld,
   input logic                      exe_req,
   input logic                      exe_hit,
   input logic                      exe_fill_rdy,
   input logic                      exe_fill_vld,
   input logic                      exe_rsp_vld,
   input logic                      st_vld,
   input logic [ADDR_W-1:0]         st_addr,
   input logic [WORD_W-1:0]         st_data,
   input logic                      wr_vld,
   input logic [LINE_WORDS-1:0]     wr_mask,
   input logic                      ic_upd_vld,
   input logic [ADDR_W-1:0]         ic_upd_addr,
   input logic [WORD_W-1:0]         ic_upd_data
);
   assert_ind_hit_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ind_hit |-> ind_req);

   assert_exe_hit_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exe_hit |-> exe_req);

   assert_fill_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ind_fill_vld |-> (ind_fill_line == ind_addr[ADDR_W-1:OFS_W]));

   assert_ind_fill_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ind_fill_vld |-> (ind_fill_rdy && ind_req && !ind_hit));

   assert_exe_fill_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exe_fill_vld |-> (exe_fill_rdy && exe_req && !exe_hit));

   assert_wr_mask_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_vld |-> ($countones(wr_mask) == 1));

   assert_ic_follows_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      st_vld |-> (ic_upd_vld && ic_upd_addr == st_addr && ic_upd_data == st_data));

   // without a fill in between, a missing address keeps missing, stores or not
   assert_miss_persists_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_req && !ind_hit && !ind_rsp_vld && !exe_rsp_vld) ##1
      (ind_req && $stable(ind_addr) && !ind_rsp_vld && !exe_rsp_vld) |-> !ind_hit);
endmodule

bind dcwt_top dcwt_chk #(
   .ADDR_W(ADDR_W), .OFS_W(OFS_W), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
) u_dcwt_chk (
   .clk(clk), .rst_n(rst_n),
   .ind_req(ind_req), .ind_addr(ind_addr), .ind_hit(ind_hit),
   .ind_fill_rdy(ind_fill_rdy), .ind_fill_vld(ind_fill_vld),
   .ind_fill_line(ind_fill_line), .ind_rsp_vld(ind_rsp_vld),
   .exe_req(exe_req), .exe_hit(exe_hit), .exe_fill_rdy(exe_fill_rdy),
   .exe_fill_vld(exe_fill_vld), .exe_rsp_vld(exe_rsp_vld),
   .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
   .wr_vld(wr_vld), .wr_mask(wr_mask),
   .ic_upd_vld(ic_upd_vld), .ic_upd_addr(ic_upd_addr), .ic_upd_data(ic_upd_data)
);

// File: tb/dcwt_top_tb_top.sv
`timescale 1ns/1ps
module dcwt_top_tb_top;
   localparam int WW = 12;
   localparam int AW = 15;
   localparam int LA = 12;
   localparam int LW = 96;

   logic clk = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic          rst_n;
   logic          ind_req, ind_hit, ind_fill_rdy, ind_fill_vld, ind_rsp_vld;
   logic [AW-1:0] ind_addr;
   logic [WW-1:0] ind_data;
   logic [LA-1:0] ind_fill_line, ind_rsp_line;
   logic [LW-1:0] ind_rsp_data;
   logic          exe_req, exe_hit, exe_fill_rdy, exe_fill_vld, exe_rsp_vld;
   logic [AW-1:0] exe_addr;
   logic [WW-1:0] exe_data;
   logic [LA-1:0] exe_fill_line, exe_rsp_line;
   logic [LW-1:0] exe_rsp_data;
   logic          st_vld, wr_vld, ic_upd_vld;
   logic [AW-1:0] st_addr, ic_upd_addr;
   logic [WW-1:0] st_data, ic_upd_data;
   logic [LA-1:0] wr_line;
   logic [7:0]    wr_mask;
   logic [LW-1:0] wr_data;

   dcwt_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .ind_req(ind_req), .ind_addr(ind_addr), .ind_hit(ind_hit), .ind_data(ind_data),
      .ind_fill_rdy(ind_fill_rdy), .ind_fill_vld(ind_fill_vld), .ind_fill_line(ind_fill_line),
      .ind_rsp_vld(ind_rsp_vld), .ind_rsp_line(ind_rsp_line), .ind_rsp_data(ind_rsp_data),
      .exe_req(exe_req), .exe_addr(exe_addr), .exe_hit(exe_hit), .exe_data(exe_data),
      .exe_fill_rdy(exe_fill_rdy), .exe_fill_vld(exe_fill_vld), .exe_fill_line(exe_fill_line),
      .exe_rsp_vld(exe_rsp_vld), .exe_rsp_line(exe_rsp_line), .exe_rsp_data(exe_rsp_data),
      .st_vld(st_vld), .st_addr(st_addr), .st_data(st_data),
      .wr_vld(wr_vld), .wr_line(wr_line), .wr_mask(wr_mask), .wr_data(wr_data),
      .ic_upd_vld(ic_upd_vld), .ic_upd_addr(ic_upd_addr), .ic_upd_data(ic_upd_data)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // reference state: per line a valid flag, a tag and eight words
   int mvalid [8];
   int mtag   [8];
   int mdata  [8][8];

   task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
      end
   endtask

   function automatic logic [LW-1:0] mk(int s);
      logic [LW-1:0] r;
      for (int w = 0; w < 8; w++) r[w*WW +: WW] = 12'((s * 331) + (w * 73) + 17);
      return r;
   endfunction

   task automatic idle();
      ind_req = 0; ind_addr = '0; ind_fill_rdy = 1; ind_rsp_vld = 0;
      ind_rsp_line = '0; ind_rsp_data = '0;
      exe_req = 0; exe_addr = '0; exe_fill_rdy = 1; exe_rsp_vld = 0;
      exe_rsp_line = '0; exe_rsp_data = '0;
      st_vld = 0; st_addr = '0; st_data = '0;
   endtask

   // Compare every output with the model for the inputs now applied,
   // then advance the model as the clock edge will.
   task automatic step();
      int ev [8];
      int et [8];
      int ed [8][8];
      int a, l, i, t, o, eh;
      #2;
      for (int k = 0; k < 8; k++) begin
         ev[k] = mvalid[k]; et[k] = mtag[k];
         for (int w = 0; w < 8; w++) ed[k][w] = mdata[k][w];
      end
      // fills: indirect then execute (R6, R7)
      if (ind_rsp_vld) begin
         l = int'(ind_rsp_line); ev[l % 8] = 1; et[l % 8] = l / 8;
         for (int w = 0; w < 8; w++) ed[l % 8][w] = int'(ind_rsp_data[w*WW +: WW]);
      end
      if (exe_rsp_vld) begin
         l = int'(exe_rsp_line); ev[l % 8] = 1; et[l % 8] = l / 8;
         for (int w = 0; w < 8; w++) ed[l % 8][w] = int'(exe_rsp_data[w*WW +: WW]);
      end
      // indirect lookup (R2, R4, R5)
      a = int'(ind_addr); i = (a / 8) % 8; t = a / 64; o = a % 8;
      eh = (ind_req && ev[i] == 1 && et[i] == t) ? 1 : 0;
      chk("R2 ind_hit", 32'(ind_hit), 32'(eh));
      chk("R2 ind_data", 32'(ind_data), (eh != 0) ? 32'(ed[i][o]) : 32'd0);
      chk("R5 ind_fill_vld", 32'(ind_fill_vld), 32'(ind_req && eh == 0 && ind_fill_rdy));
      if (ind_fill_vld) chk("R4 ind_fill_line", 32'(ind_fill_line), 32'(a / 8));
      // execute lookup (R3, R4, R5)
      a = int'(exe_addr); i = (a / 8) % 8; t = a / 64; o = a % 8;
      eh = (exe_req && ev[i] == 1 && et[i] == t) ? 1 : 0;
      chk("R3 exe_hit", 32'(exe_hit), 32'(eh));
      chk("R3 exe_data", 32'(exe_data), (eh != 0) ? 32'(ed[i][o]) : 32'd0);
      chk("R5 exe_fill_vld", 32'(exe_fill_vld), 32'(exe_req && eh == 0 && exe_fill_rdy));
      if (exe_fill_vld) chk("R4 exe_fill_line", 32'(exe_fill_line), 32'(a / 8));
      // store (R8, R9, R10, R11)
      chk("R8 wr_vld", 32'(wr_vld), 32'(st_vld));
      chk("R9 ic_upd_vld", 32'(ic_upd_vld), 32'(st_vld));
      if (st_vld) begin
         a = int'(st_addr); i = (a / 8) % 8; t = a / 64; o = a % 8;
         chk("R8 wr_line", 32'(wr_line), 32'(a / 8));
         chk("R8 wr_mask", 32'(wr_mask), 32'(1 << o));
         for (int w = 0; w < 8; w++)
            chk("R8 wr_data slot", 32'(wr_data[w*WW +: WW]), (w == o) ? 32'(st_data) : 32'd0);
         chk("R9 ic_upd_addr", 32'(ic_upd_addr), 32'(st_addr));
         chk("R9 ic_upd_data", 32'(ic_upd_data), 32'(st_data));
         if (ev[i] == 1 && et[i] == t) ed[i][o] = int'(st_data);
      end
      for (int k = 0; k < 8; k++) begin
         mvalid[k] = ev[k]; mtag[k] = et[k];
         for (int w = 0; w < 8; w++) mdata[k][w] = ed[k][w];
      end
      @(negedge clk);
   endtask

   function automatic int raddr();
      int ts, tg;
      ts = int'($urandom % 4);
      tg = (ts == 3) ? 511 : ts * 100;
      return tg * 64 + int'($urandom % 64);
   endfunction

   initial begin
      logic [LW-1:0] l1;
      for (int k = 0; k < 8; k++) begin
         mvalid[k] = 0; mtag[k] = 0;
         for (int w = 0; w < 8; w++) mdata[k][w] = 0;
      end
      idle();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1, R4: empty after reset, misses raise fill commands
      ind_req = 1; ind_addr = 15'(42*8 + 3);
      exe_req = 1; exe_addr = 15'(0);
      #1;
      chk("R1 ind_hit after reset", 32'(ind_hit), 0);
      chk("R1 exe_hit after reset", 32'(exe_hit), 0);
      chk("R4 ind_fill_vld", 32'(ind_fill_vld), 1);
      chk("R4 ind_fill_line", 32'(ind_fill_line), 42);
      step();

      // R5: channel busy means no command; retries continue
      exe_req = 0; ind_fill_rdy = 0;
      #1; chk("R5 no fill when busy", 32'(ind_fill_vld), 0);
      step();
      step();
      ind_fill_rdy = 1;
      #1; chk("R5 fill reissued", 32'(ind_fill_vld), 1);
      step();

      // R6: response visible in its own cycle
      l1 = mk(1);
      ind_rsp_vld = 1; ind_rsp_line = 12'(42); ind_rsp_data = l1;
      #1;
      chk("R6 same-cycle hit", 32'(ind_hit), 1);
      chk("R6 same-cycle data", 32'(ind_data), 32'(l1[3*WW +: WW]));
      step();
      ind_rsp_vld = 0; ind_addr = 15'(42*8 + 7);
      #1; chk("R6 installed word", 32'(ind_data), 32'(l1[7*WW +: WW]));
      step();

      // R3: both ports hit in one cycle
      exe_rsp_vld = 1; exe_rsp_line = 12'(78); exe_rsp_data = mk(2);
      exe_req = 1; exe_addr = 15'(78*8); ind_addr = 15'(42*8 + 3);
      #1;
      chk("R3 exe_hit", 32'(exe_hit), 1);
      chk("R3 exe_data", 32'(exe_data), 32'(mk(2)) & 32'hfff);
      chk("R3 ind_hit concurrent", 32'(ind_hit), 1);
      step();
      idle();

      // R7: two responses to index 4, execute line stays
      ind_rsp_vld = 1; ind_rsp_line = 12'(28); ind_rsp_data = mk(3);
      exe_rsp_vld = 1; exe_rsp_line = 12'(60); exe_rsp_data = mk(4);
      step();
      idle();
      ind_req = 1; ind_addr = 15'(28*8 + 1);
      exe_req = 1; exe_addr = 15'(60*8 + 1);
      #1;
      chk("R7 indirect line replaced", 32'(ind_hit), 0);
      chk("R7 execute line kept", 32'(exe_hit), 1);
      chk("R7 execute data", 32'(exe_data), 32'(mk(4)[1*WW +: WW]));
      step();
      idle();

      // R12 then R10: store to a resident word
      st_vld = 1; st_addr = 15'(42*8 + 3); st_data = 12'h5a5;
      ind_req = 1; ind_addr = 15'(42*8 + 3);
      #1;
      chk("R12 old word during store", 32'(ind_data), 32'(l1[3*WW +: WW]));
      chk("R8 mask bit 3", 32'(wr_mask), 32'h08);
      chk("R9 icache addr", 32'(ic_upd_addr), 32'(42*8 + 3));
      step();
      st_vld = 0;
      #1; chk("R10 patched word", 32'(ind_data), 32'h5a5);
      step();
      idle();

      // R10: store into a line filled in the same cycle
      ind_rsp_vld = 1; ind_rsp_line = 12'(105); ind_rsp_data = mk(5);
      st_vld = 1; st_addr = 15'(105*8 + 2); st_data = 12'h3c3;
      step();
      idle();
      exe_req = 1; exe_addr = 15'(105*8 + 2);
      #1; chk("R10 store after fill", 32'(exe_data), 32'h3c3);
      step();
      idle();

      // R11: store to absent line sharing index 2 with a resident one
      st_vld = 1; st_addr = 15'(50*8 + 3); st_data = 12'h777;
      step();
      idle();
      ind_req = 1; ind_addr = 15'(50*8 + 3);
      exe_req = 1; exe_addr = 15'(42*8 + 3);
      #1;
      chk("R11 no allocate", 32'(ind_hit), 0);
      chk("R11 resident line intact", 32'(exe_data), 32'h5a5);
      step();

      // random collisions of fills, lookups and stores
      for (int n = 0; n < 4000; n++) begin
         ind_req = 1'($urandom % 4 != 0); ind_addr = 15'(raddr());
         exe_req = 1'($urandom % 4 != 0); exe_addr = 15'(raddr());
         ind_fill_rdy = 1'($urandom % 3 != 0);
         exe_fill_rdy = 1'($urandom % 3 != 0);
         ind_rsp_vld = 1'($urandom % 4 == 0);
         ind_rsp_line = 12'(raddr() / 8);
         ind_rsp_data = {$urandom, $urandom, $urandom};
         exe_rsp_vld = 1'($urandom % 4 == 0);
         exe_rsp_line = 12'(raddr() / 8);
         exe_rsp_data = {$urandom, $urandom, $urandom};
         st_vld = 1'($urandom % 3 == 0); st_addr = 15'(raddr()); st_data = 12'($urandom);
         step();
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(64'd20 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R1..all actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule